// File: doc/BRIEF.md
# Calendar Alarm Matcher with Interrupt

This block watches a running clock and calendar and raises an alarm when the time reaches a programmed value. It receives six BCD fields: seconds, minutes, hours, weekday, date and month. It compares them with six programmed alarm fields. Each field has its own enable bit, and a disabled field matches anything. One comparison can therefore fire once a minute, once an hour, on one weekday, or at one exact date and time. The comparison is made only in the cycle where the time counter updates, so a matching second gives exactly one event.

A match produces a one-cycle event strobe and sets a sticky alarm flag. It also drives an interrupt line that is active low and open-drain in style. The line is modelled as an output enable that is 1 while the pin would be pulled low. A mode input selects how the line behaves. In level mode the line follows the flag until software clears the flag. In pulse mode the line is held for a fixed number of cycles and then releases by itself. The flag can be cleared by an explicit write-zero strobe. It can also be cleared by a status-read strobe when auto-clear is enabled. A match in the same cycle as a clear keeps the flag set.

Top module: `cal_alarm_irq`

## Requirements
- R1: The match is evaluated only when `tick` is 1. A match occurs when at least one field is enabled and every enabled field of `time_now` equals the same field of `alarm_val`. A match drives `alarm_evt` to 1 for exactly the one cycle after the tick cycle.
- R2: A field whose bit in `alarm_en` is 0 is ignored. For example, enabling only seconds fires on every tick whose seconds field equals the alarm seconds, whatever the other fields hold.
- R3: When `alarm_en` is all zero, no event, flag or interrupt is ever produced, even if all fields are equal.
- R4: A match sets `alarm_flag` to 1 in the cycle after the tick. The flag stays 1 until it is cleared.
- R5: `flag_clr` clears the flag on the next cycle. `rd_clr` clears it only while `auto_clr_en` is 1; otherwise `rd_clr` has no effect.
- R6: If a match occurs in the same cycle as a clear strobe, the flag is 1 afterwards.
- R7: When `pulse_mode` is 0 (level mode), `irq_oe` equals `alarm_flag` one cycle after the inputs, so the line stays driven until the flag is cleared.
- R8: When `pulse_mode` is 1, `irq_oe` is 1 for exactly `PULSE_LEN` cycles starting the cycle after a match, then returns to 0 while the flag stays set. A new match during a pulse restarts the full count.
- R9: While `rst_n` is 0 and after it is released, `alarm_evt`, `alarm_flag` and `irq_oe` are 0 until a match.
- R10: Field i occupies bits [8i+7:8i] of `time_now` and `alarm_val` and bit i of `alarm_en`. The order is seconds (0), minutes (1), hours (2), weekday (3), date (4), month (5). All 8 bits of a field are compared, so the 12/24-hour and AM/PM bits of the hours field take part.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time fields were updated this cycle |
| time_now | input | 48 | Current BCD fields, packed as in R10 |
| alarm_val | input | 48 | Programmed alarm fields, same packing |
| alarm_en | input | 6 | Per-field compare enable |
| pulse_mode | input | 1 | 0 = level interrupt, 1 = pulse interrupt |
| flag_clr | input | 1 | Write-zero strobe for the alarm flag |
| rd_clr | input | 1 | Status-read strobe |
| auto_clr_en | input | 1 | Lets `rd_clr` clear the flag |
| alarm_evt | output | 1 | One-cycle match event |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq_oe | output | 1 | 1 = interrupt pin pulled low |

## Verification
The assertions check these rules on every cycle:
- an event appears only after a tick with at least one enabled field;
- a match always wins over a clear;
- an uncleared flag stays set;
- in level mode the line follows the flag;
- the pulse counter never exceeds its length.

Only the bench scenarios can show the behaviour seen across several cycles. This covers the periodic firing with masked fields, the exact length of a pulse and its restart, the gating of the read clear, and the effect of the hour format bits.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
    localparam int FIELD_W    = 8;
    localparam int NUM_FIELDS = 6;

    typedef enum int {
        FLD_SEC   = 0,
        FLD_MIN   = 1,
        FLD_HOUR  = 2,
        FLD_WDAY  = 3,
        FLD_DATE  = 4,
        FLD_MONTH = 5
    } field_idx_e;
endpackage

// File: rtl/cal_alarm_field_cmp.sv
module cal_alarm_field_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] now_f,
    input  logic [W-1:0] alm_f,
    input  logic         en_f,
    output logic         hit_f
);
    // A masked field is always a hit; an enabled one needs full equality.
    always_comb begin
        hit_f = (!en_f) || (now_f == alm_f);
    end
endmodule

// File: rtl/cal_alarm_irq_ctl.sv
module cal_alarm_irq_ctl #(
    parameter int PULSE_LEN = 4,
    localparam int CNT_W = $clog2(PULSE_LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic match,
    input  logic pulse_mode,
    input  logic flag_clr,
    input  logic rd_clr,
    input  logic auto_clr_en,
    output logic evt,
    output logic flag,
    output logic irq_oe
);
    typedef struct packed {
        logic             evt;
        logic             flag;
        logic             irq;
        logic [CNT_W-1:0] cnt;
    } ctl_state_t;

    ctl_state_t st_q, st_d;
    logic       clr_req;

    always_comb begin
        clr_req = flag_clr || (rd_clr && auto_clr_en);
        st_d    = st_q;
        st_d.evt = match;
        // Set has priority over any clear arriving in the same cycle.
        if (match) begin
            st_d.flag = 1'b1;
        end else if (clr_req) begin
            st_d.flag = 1'b0;
        end
        if (match) begin
            st_d.cnt = CNT_W'(PULSE_LEN);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        st_d.irq = pulse_mode ? (st_d.cnt != '0) : st_d.flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign evt    = st_q.evt;
    assign flag   = st_q.flag;
    assign irq_oe = st_q.irq;

    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(match) |-> flag);

    p_clear_takes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!match && flag_clr) |-> !flag);

    p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flag && !flag_clr && !(rd_clr && auto_clr_en)) |-> flag);

    p_level_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!pulse_mode) |-> (irq_oe == flag));

    p_pulse_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(PULSE_LEN));

    p_pulse_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pulse_mode && !match && st_q.cnt <= CNT_W'(1)) |-> !irq_oe);
endmodule

// File: rtl/cal_alarm_irq.sv
module cal_alarm_irq
    import cal_alarm_pkg::*;
#(
    parameter int FW        = FIELD_W,
    parameter int NF        = NUM_FIELDS,
    parameter int PULSE_LEN = 4,
    localparam int VEC_W    = FW * NF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [VEC_W-1:0] time_now,
    input  logic [VEC_W-1:0] alarm_val,
    input  logic [NF-1:0]    alarm_en,
    input  logic             pulse_mode,
    input  logic             flag_clr,
    input  logic             rd_clr,
    input  logic             auto_clr_en,
    output logic             alarm_evt,
    output logic             alarm_flag,
    output logic             irq_oe
);
    logic [NF-1:0] hits;
    logic          match;

    for (genvar i = 0; i < NF; i++) begin : g_field
        cal_alarm_field_cmp #(.W(FW)) u_cmp (
            .now_f (time_now[i*FW +: FW]),
            .alm_f (alarm_val[i*FW +: FW]),
            .en_f  (alarm_en[i]),
            .hit_f (hits[i])
        );
    end

    always_comb begin
        match = tick && (|alarm_en) && (&hits);
    end

    cal_alarm_irq_ctl #(.PULSE_LEN(PULSE_LEN)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .match       (match),
        .pulse_mode  (pulse_mode),
        .flag_clr    (flag_clr),
        .rd_clr      (rd_clr),
        .auto_clr_en (auto_clr_en),
        .evt         (alarm_evt),
        .flag        (alarm_flag),
        .irq_oe      (irq_oe)
    );

    p_evt_needs_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_evt |-> $past(tick));

    p_no_enables_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(alarm_en == '0) |-> !alarm_evt);
endmodule

// File: tb/sim_cal_alarm_irq.sv
module sim_cal_alarm_irq;
    localparam int PL = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [47:0] time_now = '0;
    logic [47:0] alarm_val = '0;
    logic [5:0]  alarm_en = '0;
    logic        pulse_mode = 1'b0;
    logic        flag_clr = 1'b0;
    logic        rd_clr = 1'b0;
    logic        auto_clr_en = 1'b0;
    logic        alarm_evt, alarm_flag, irq_oe;

    always #2.5 clk = ~clk;

    cal_alarm_irq #(.PULSE_LEN(PL)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .time_now(time_now),
        .alarm_val(alarm_val), .alarm_en(alarm_en), .pulse_mode(pulse_mode),
        .flag_clr(flag_clr), .rd_clr(rd_clr), .auto_clr_en(auto_clr_en),
        .alarm_evt(alarm_evt), .alarm_flag(alarm_flag), .irq_oe(irq_oe)
    );

    typedef struct {
        logic  evt;
        logic  flag;
        logic  irq;
        string tag;
    } exp_t;

    exp_t sb[$];
    int   n_vec  = 0;
    int   n_fail = 0;
    logic m_flag = 1'b0;
    int   m_cnt  = 0;
    bit   done   = 0;

    function automatic logic [47:0] pack(input logic [7:0] s, input logic [7:0] mi,
                                         input logic [7:0] h, input logic [7:0] wd,
                                         input logic [7:0] dt, input logic [7:0] mo);
        return {mo, dt, wd, h, mi, s};
    endfunction

    // Driver: model the expected result of the inputs held now, push it, advance.
    task automatic cyc(input string tag);
        exp_t e;
        logic m;
        m = tick && (alarm_en != 0);
        for (int i = 0; i < 6; i++)
            if (alarm_en[i] && time_now[i*8 +: 8] != alarm_val[i*8 +: 8]) m = 1'b0;
        if (m) m_flag = 1'b1;
        else if (flag_clr || (rd_clr && auto_clr_en)) m_flag = 1'b0;
        if (m) m_cnt = PL;
        else if (m_cnt > 0) m_cnt--;
        e.evt  = m;
        e.flag = m_flag;
        e.irq  = pulse_mode ? (m_cnt != 0) : m_flag;
        e.tag  = tag;
        sb.push_back(e);
        @(negedge clk);
        tick = 1'b0; flag_clr = 1'b0; rd_clr = 1'b0;
    endtask

    task automatic idle(input int n, input string tag);
        for (int k = 0; k < n; k++) cyc(tag);
    endtask

    // Monitor: compare just after each edge.
    always begin
        @(posedge clk);
        #1;
        if (rst_n && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_vec++;
            if ({alarm_evt, alarm_flag, irq_oe} !== {e.evt, e.flag, e.irq}) begin
                n_fail++;
                $display("FAIL %s: evt/flag/irq actual %b%b%b expected %b%b%b",
                         e.tag, alarm_evt, alarm_flag, irq_oe, e.evt, e.flag, e.irq);
            end
        end
    end

    initial begin
        int cycles = 0;
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                n_fail++;
                $display("FAIL watchdog: actual hung expected finish");
                $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        n_vec++;
        if ({alarm_evt, alarm_flag, irq_oe} !== 3'b000) begin
            n_fail++;
            $display("FAIL R9: reset outputs actual %b%b%b expected 000",
                     alarm_evt, alarm_flag, irq_oe);
        end
        rst_n = 1'b1;
        idle(2, "R9");

        // R3: everything equal but no enables.
        alarm_val = pack(8'h30, 8'h15, 8'h08, 8'h02, 8'h21, 8'h03);
        time_now  = alarm_val;
        tick = 1'b1; cyc("R3");
        tick = 1'b1; cyc("R3");
        idle(1, "R3");

        // R1/R4/R7: full match in level mode.
        alarm_en = 6'h3F;
        time_now = alarm_val;                      // equal but no tick
        cyc("R1 no tick");
        tick = 1'b1; cyc("R1 full match");
        idle(2, "R7 level hold");
        time_now = pack(8'h31, 8'h15, 8'h08, 8'h02, 8'h21, 8'h03);
        tick = 1'b1; cyc("R4 sticky");
        idle(1, "R4");

        // R5: read clear gated by auto-clear, then write clear.
        rd_clr = 1'b1; cyc("R5 rd ignored");
        idle(1, "R5");
        auto_clr_en = 1'b1; rd_clr = 1'b1; cyc("R5 rd clears");
        idle(1, "R5");
        time_now = alarm_val; tick = 1'b1; cyc("R1 refire");
        flag_clr = 1'b1; cyc("R5 wr clear");
        idle(1, "R5");

        // R6: match and clear together.
        tick = 1'b1; flag_clr = 1'b1; rd_clr = 1'b1; cyc("R6 set wins");
        flag_clr = 1'b1; cyc("R6");
        auto_clr_en = 1'b0;

        // R2: seconds only, other fields vary.
        alarm_en  = 6'h01;
        alarm_val = pack(8'h45, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01);
        time_now  = pack(8'h45, 8'h07, 8'h11, 8'h05, 8'h12, 8'h09);
        tick = 1'b1; cyc("R2 every minute");
        flag_clr = 1'b1; cyc("R2");
        time_now  = pack(8'h45, 8'h08, 8'h23, 8'h06, 8'h30, 8'h11);
        tick = 1'b1; cyc("R2 next minute");
        time_now  = pack(8'h46, 8'h08, 8'h23, 8'h06, 8'h30, 8'h11);
        flag_clr = 1'b1; tick = 1'b1; cyc("R2 miss");
        idle(1, "R2");

        // R10: hour field compared with its format bits; weekday position.
        alarm_en  = 6'h04;
        alarm_val = pack(8'h00, 8'h00, 8'h25, 8'h00, 8'h01, 8'h01);
        time_now  = pack(8'h00, 8'h00, 8'h05, 8'h00, 8'h01, 8'h01);
        tick = 1'b1; cyc("R10 pm bit differs");
        time_now  = pack(8'h10, 8'h20, 8'h25, 8'h03, 8'h01, 8'h01);
        tick = 1'b1; cyc("R10 hour match");
        flag_clr = 1'b1; cyc("R10");
        alarm_en  = 6'h08;
        alarm_val = pack(8'h00, 8'h00, 8'h00, 8'h04, 8'h01, 8'h01);
        time_now  = pack(8'h04, 8'h04, 8'h04, 8'h03, 8'h04, 8'h04);
        tick = 1'b1; cyc("R10 weekday miss");
        time_now  = pack(8'h00, 8'h00, 8'h00, 8'h04, 8'h09, 8'h09);
        tick = 1'b1; cyc("R10 weekday hit");
        flag_clr = 1'b1; cyc("R10");

        // R8: pulse mode, length, release, retrigger.
        pulse_mode = 1'b1;
        idle(1, "R8");
        tick = 1'b1; cyc("R8 pulse start");
        idle(PL + 2, "R8 pulse length");
        tick = 1'b1; cyc("R8 pulse again");
        idle(2, "R8");
        tick = 1'b1; cyc("R8 retrigger");
        idle(PL + 2, "R8 retrigger length");
        flag_clr = 1'b1; cyc("R8 clear");
        idle(2, "R8");

        repeat (2) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule